// File: doc/BRIEF.md
# Line-Access Field Memory with Port Address Sequencers

This block is a small field store that is reached one line at a time. It has one serial write port and two serial read ports. Each port has its own address sequencer, and each sequencer keeps a column address and a line address of its own. A full-size field is 768 words by 313 lines, so the column runs 0..767 and the line runs 0..312. The `COLS` and `LINES` parameters set the field size. The defaults keep the behavioural array small (24 x 13) so that it simulates quickly.

A port receives a starting column and line through a serial address input. The port then moves through the field line by line. Each access strobe touches the current word and moves the column on by one. At every line start, a 2-bit mode code picks the new address:
- a fresh random load;
- holding the line;
- a jump back to the last loaded starting column;
- a jump combined with a move to the next line, which lets a port walk a rectangular block.

On the write port, a write enable acts as a per-word mask.

Each sequencer is a three-state machine:
- `PS_IDLE`: no line has been opened since reset.
- `PS_RUN`: accesses are taken.
- `PS_EOL`: the last column has been accessed.

Its transitions are:
- OPEN: any state goes to `PS_RUN` on a line start.
- FINISH: `PS_RUN` goes to `PS_EOL` when a step lands on the last column.
- STAY: no other input changes the state.

Top module: `fm_line_access`

## Requirements
- R1: After reset both read outputs are zero. Every sequencer is in `PS_IDLE`, and access strobes are ignored until the port's first line start.
- R2: While a port's shift enable is high, each clock shifts one bit MSB first into a 10-bit column register and a 9-bit line register. The line register keeps the last 9 bits shifted. The values take effect only at a mode 00 line start. A column above `COLS-1` is clamped to `COLS-1`, and a line above `LINES-1` is clamped to `LINES-1`.
- R3: Mode 00 (random load) sets the column and line to the shifted values and records that column as the port's initial X.
- R4: Mode 01 (line hold) restarts the column at 0 and keeps the line.
- R5: Mode 10 (jump) sets the column to the recorded initial X and keeps the line.
- R6: Mode 11 (jump and advance) sets the column to the initial X and adds one to the line. The line wraps from `LINES-1` to 0.
- R7: In `PS_RUN` a step accesses word (line, column) and then moves the column on by one. The step on column `COLS-1` is still taken, but the column stays there and the state becomes `PS_EOL`. Later steps have no effect until the next line start.
- R8: A write step with the write enable low leaves the addressed word unchanged, and the column still moves on.
- R9: A read step presents the addressed word on the port's data output at the clock edge after the step. The output holds between read steps. A read and a write of the same word in the same cycle returns the old contents.
- R10: When a line start and a step arrive in the same cycle, the line start is applied and the step is discarded: no access is made and the column does not move.
- R11: The three ports keep independent address state. Activity on one port never moves another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all ports |
| rst | input | 1 | Synchronous reset, active high |
| wr_sa_en | input | 1 | Write port serial address shift enable |
| wr_sa_x | input | 1 | Write port serial column bit |
| wr_sa_y | input | 1 | Write port serial line bit |
| wr_lstart | input | 1 | Write port line start strobe |
| wr_mode | input | 2 | Write port address set mode at line start |
| wr_step | input | 1 | Write port access strobe |
| wr_data | input | DW | Write data |
| wr_ie | input | 1 | Write enable (mask when low) |
| ra_sa_en | input | 1 | Read port A serial address shift enable |
| ra_sa_x | input | 1 | Read port A serial column bit |
| ra_sa_y | input | 1 | Read port A serial line bit |
| ra_lstart | input | 1 | Read port A line start strobe |
| ra_mode | input | 2 | Read port A address set mode |
| ra_step | input | 1 | Read port A access strobe |
| ra_data | output | DW | Read port A data |
| rb_sa_en | input | 1 | Read port B serial address shift enable |
| rb_sa_x | input | 1 | Read port B serial column bit |
| rb_sa_y | input | 1 | Read port B serial line bit |
| rb_lstart | input | 1 | Read port B line start strobe |
| rb_mode | input | 2 | Read port B address set mode |
| rb_step | input | 1 | Read port B access strobe |
| rb_data | output | DW | Read port B data |

## Verification
Two collisions are provoked in this design.

The first is a line start and a step on the same port in the same cycle. Read port B is opened at column 2 and stepped twice. A jump line start is then raised together with a step. The bench requires the output to keep the previous word, and the next step to return the word at column 2.

The second is a write and a read of one word in a single cycle. The write port and read port A are opened on the same line and stepped together. The bench expects the old word from that read, and the new word on a later re-read.

The remaining checks compare every word against an arithmetic pattern. They sweep the whole field with the jump-and-advance mode through the line wrap.

// File: rtl/fm_pkg.sv
package fm_pkg;
    typedef enum logic [1:0] {
        MODE_LOAD      = 2'b00,
        MODE_HOLD      = 2'b01,
        MODE_JUMP      = 2'b10,
        MODE_JUMP_NEXT = 2'b11
    } lmode_t;

    typedef enum logic [1:0] {
        PS_IDLE = 2'b00,
        PS_RUN  = 2'b01,
        PS_EOL  = 2'b10
    } pstate_t;
endpackage

// File: rtl/fm_serial_addr.sv
module fm_serial_addr #(
    parameter int XW = 10,
    parameter int YW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          shift_en,
    input  logic          x_bit,
    input  logic          y_bit,
    output logic [XW-1:0] x_val,
    output logic [YW-1:0] y_val
);
    always_ff @(posedge clk) begin
        if (rst) begin
            x_val <= '0;
            y_val <= '0;
        end else if (shift_en) begin
            x_val <= {x_val[XW-2:0], x_bit};
            y_val <= {y_val[YW-2:0], y_bit};
        end
    end
endmodule

// File: rtl/fm_port_seq.sv
module fm_port_seq
    import fm_pkg::*;
#(
    parameter int COLS  = 24,
    parameter int LINES = 13,
    parameter int XW    = 10,
    parameter int YW    = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sa_en,
    input  logic          sa_x,
    input  logic          sa_y,
    input  logic          lstart,
    input  logic [1:0]    mode,
    input  logic          step,
    output logic [XW-1:0] col,
    output logic [YW-1:0] line,
    output logic          acc
);
    localparam logic [XW-1:0] COL_LAST  = XW'(COLS - 1);
    localparam logic [YW-1:0] LINE_LAST = YW'(LINES - 1);

    logic [XW-1:0] x_sh, x_ld, x_init;
    logic [YW-1:0] y_sh, y_ld;
    pstate_t       state, nstate;

    fm_serial_addr #(.XW(XW), .YW(YW)) u_sa (
        .clk(clk), .rst(rst), .shift_en(sa_en),
        .x_bit(sa_x), .y_bit(sa_y), .x_val(x_sh), .y_val(y_sh)
    );

    assign x_ld = (x_sh > COL_LAST)  ? COL_LAST  : x_sh;
    assign y_ld = (y_sh > LINE_LAST) ? LINE_LAST : y_sh;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= PS_IDLE;
        else     state <= nstate;
    end

    // transitions: OPEN, FINISH, STAY
    always_comb begin
        nstate = state;
        if (lstart) begin
            nstate = PS_RUN;
        end else begin
            unique case (state)
                PS_IDLE: nstate = PS_IDLE;
                PS_RUN:  if (step && col == COL_LAST) nstate = PS_EOL;
                PS_EOL:  nstate = PS_EOL;
                default: nstate = PS_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        acc = step && !lstart && (state == PS_RUN);
    end

    // address registers
    always_ff @(posedge clk) begin
        if (rst) begin
            col    <= '0;
            line   <= '0;
            x_init <= '0;
        end else if (lstart) begin
            unique case (lmode_t'(mode))
                MODE_LOAD: begin
                    col    <= x_ld;
                    line   <= y_ld;
                    x_init <= x_ld;
                end
                MODE_HOLD: col <= '0;
                MODE_JUMP: col <= x_init;
                MODE_JUMP_NEXT: begin
                    col  <= x_init;
                    line <= (line == LINE_LAST) ? '0 : line + YW'(1);
                end
            endcase
        end else if (acc && col != COL_LAST) begin
            col <= col + XW'(1);
        end
    end

    // R7
    col_range_chk: assert property (@(posedge clk) disable iff (rst)
        col <= COL_LAST);
    // R6
    line_range_chk: assert property (@(posedge clk) disable iff (rst)
        line <= LINE_LAST);
    // R4
    hold_line_chk: assert property (@(posedge clk) disable iff (rst)
        (lstart && mode == 2'b01) |=> (col == '0 && $stable(line)));
    // R5
    jump_col_chk: assert property (@(posedge clk) disable iff (rst)
        (lstart && mode[1]) |=> col == $past(x_init));
    // R6
    next_line_chk: assert property (@(posedge clk) disable iff (rst)
        (lstart && mode == 2'b11) |=>
        line == (($past(line) == LINE_LAST) ? '0 : $past(line) + YW'(1)));
    // R7
    eol_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == PS_EOL && !lstart) |=> ($stable(col) && $stable(line)));
    // R10
    start_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (lstart && step) |-> !acc);
endmodule

// File: rtl/fm_store.sv
module fm_store #(
    parameter int DW    = 8,
    parameter int COLS  = 24,
    parameter int LINES = 13,
    parameter int XW    = 10,
    parameter int YW    = 9,
    parameter int NR    = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   w_acc,
    input  logic                   w_en,
    input  logic [XW-1:0]          w_col,
    input  logic [YW-1:0]          w_line,
    input  logic [DW-1:0]          w_data,
    input  logic [NR-1:0]          r_acc,
    input  logic [NR-1:0][XW-1:0]  r_col,
    input  logic [NR-1:0][YW-1:0]  r_line,
    output logic [NR-1:0][DW-1:0]  r_data
);
    localparam int DEPTH = COLS * LINES;
    localparam int AW    = $clog2(DEPTH);

    logic [DW-1:0] mem [DEPTH];

    function automatic logic [AW-1:0] word_idx(input logic [XW-1:0] c,
                                               input logic [YW-1:0] l);
        return AW'(int'(l) * COLS + int'(c));
    endfunction

    always_ff @(posedge clk) begin
        if (w_acc && w_en) mem[word_idx(w_col, w_line)] <= w_data;
    end

    for (genvar r = 0; r < NR; r++) begin : g_rd
        always_ff @(posedge clk) begin
            if (rst)           r_data[r] <= '0;
            else if (r_acc[r]) r_data[r] <= mem[word_idx(r_col[r], r_line[r])];
        end

        // R9
        rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
            !r_acc[r] |=> $stable(r_data[r]));
    end
endmodule

// File: rtl/fm_line_access.sv
module fm_line_access #(
    parameter int DW    = 8,
    parameter int COLS  = 24,
    parameter int LINES = 13,
    parameter int XW    = 10,
    parameter int YW    = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_sa_en,
    input  logic          wr_sa_x,
    input  logic          wr_sa_y,
    input  logic          wr_lstart,
    input  logic [1:0]    wr_mode,
    input  logic          wr_step,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_ie,
    input  logic          ra_sa_en,
    input  logic          ra_sa_x,
    input  logic          ra_sa_y,
    input  logic          ra_lstart,
    input  logic [1:0]    ra_mode,
    input  logic          ra_step,
    output logic [DW-1:0] ra_data,
    input  logic          rb_sa_en,
    input  logic          rb_sa_x,
    input  logic          rb_sa_y,
    input  logic          rb_lstart,
    input  logic [1:0]    rb_mode,
    input  logic          rb_step,
    output logic [DW-1:0] rb_data
);
    localparam int NP = 3;

    logic [NP-1:0]         p_sa_en, p_sa_x, p_sa_y, p_lstart, p_step, p_acc;
    logic [NP-1:0][1:0]    p_mode;
    logic [NP-1:0][XW-1:0] p_col;
    logic [NP-1:0][YW-1:0] p_line;
    logic [1:0][DW-1:0]    rd;

    assign p_sa_en  = {rb_sa_en,  ra_sa_en,  wr_sa_en};
    assign p_sa_x   = {rb_sa_x,   ra_sa_x,   wr_sa_x};
    assign p_sa_y   = {rb_sa_y,   ra_sa_y,   wr_sa_y};
    assign p_lstart = {rb_lstart, ra_lstart, wr_lstart};
    assign p_step   = {rb_step,   ra_step,   wr_step};
    assign p_mode   = {rb_mode,   ra_mode,   wr_mode};

    for (genvar p = 0; p < NP; p++) begin : g_port
        fm_port_seq #(.COLS(COLS), .LINES(LINES), .XW(XW), .YW(YW)) u_seq (
            .clk(clk), .rst(rst),
            .sa_en(p_sa_en[p]), .sa_x(p_sa_x[p]), .sa_y(p_sa_y[p]),
            .lstart(p_lstart[p]), .mode(p_mode[p]), .step(p_step[p]),
            .col(p_col[p]), .line(p_line[p]), .acc(p_acc[p])
        );
    end

    fm_store #(.DW(DW), .COLS(COLS), .LINES(LINES), .XW(XW), .YW(YW), .NR(2)) u_store (
        .clk(clk), .rst(rst),
        .w_acc(p_acc[0]), .w_en(wr_ie), .w_col(p_col[0]), .w_line(p_line[0]),
        .w_data(wr_data),
        .r_acc(p_acc[2:1]), .r_col(p_col[2:1]), .r_line(p_line[2:1]),
        .r_data(rd)
    );

    assign ra_data = rd[0];
    assign rb_data = rd[1];
endmodule

// File: tb/fm_line_access_tb.sv
module fm_line_access_tb_top;
    localparam int COLS  = 24;
    localparam int LINES = 13;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [2:0] sa_en = '0, sa_x = '0, sa_y = '0, lst = '0, stp = '0;
    logic [1:0] md [3];
    logic [7:0] wr_data = '0;
    logic       wr_ie = 1'b1;
    logic [7:0] ra_data, rb_data;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    fm_line_access dut_i (
        .clk(clk), .rst(rst),
        .wr_sa_en(sa_en[0]), .wr_sa_x(sa_x[0]), .wr_sa_y(sa_y[0]),
        .wr_lstart(lst[0]), .wr_mode(md[0]), .wr_step(stp[0]),
        .wr_data(wr_data), .wr_ie(wr_ie),
        .ra_sa_en(sa_en[1]), .ra_sa_x(sa_x[1]), .ra_sa_y(sa_y[1]),
        .ra_lstart(lst[1]), .ra_mode(md[1]), .ra_step(stp[1]), .ra_data(ra_data),
        .rb_sa_en(sa_en[2]), .rb_sa_x(sa_x[2]), .rb_sa_y(sa_y[2]),
        .rb_lstart(lst[2]), .rb_mode(md[2]), .rb_step(stp[2]), .rb_data(rb_data)
    );

    function automatic logic [7:0] pat(input int l, input int c);
        return 8'((l * 31 + c * 5 + 7) & 255);
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load(input int p, input int x, input int y);
        for (int i = 9; i >= 0; i--) begin
            sa_en[p] = 1'b1;
            sa_x[p]  = x[i];
            sa_y[p]  = (i < 9) ? y[i] : 1'b0;
            @(negedge clk);
        end
        sa_en[p] = 1'b0;
    endtask

    task automatic line_start(input int p, input logic [1:0] m);
        lst[p] = 1'b1; md[p] = m;
        @(negedge clk);
        lst[p] = 1'b0;
    endtask

    task automatic step(input int p);
        stp[p] = 1'b1;
        @(negedge clk);
        stp[p] = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        md[0] = 2'b00; md[1] = 2'b00; md[2] = 2'b00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset ra", ra_data, 8'h00);
        check("R1 reset rb", rb_data, 8'h00);
        step(1); step(2);
        check("R1 idle step ra", ra_data, 8'h00);
        check("R1 idle step rb", rb_data, 8'h00);

        // fill the field: load (0,0), then jump-and-advance each line
        load(0, 0, 0);
        line_start(0, 2'b00);
        for (int l = 0; l < LINES; l++) begin
            for (int c = 0; c < COLS; c++) begin
                wr_data = pat(l, c);
                step(0);
            end
            wr_data = 8'hEE;         // steps past line end: must be ignored (R7)
            step(0); step(0);
            line_start(0, 2'b11);
        end

        // read port A sweeps all lines (R3, R6, R7, R9)
        load(1, 0, 0);
        line_start(1, 2'b00);
        for (int l = 0; l < LINES; l++) begin
            for (int c = 0; c < COLS; c++) begin
                step(1);
                check("R7 sweep word", ra_data, pat(l, c));
            end
            step(1);
            check("R7 step past end ignored", ra_data, pat(l, COLS - 1));
            line_start(1, 2'b11);
        end
        step(1);
        check("R6 line wrap to 0", ra_data, pat(0, 0));

        // R2 R3 random load on port B, then modes
        load(2, 5, 9);
        line_start(2, 2'b00);
        step(2); check("R3 random load", rb_data, pat(9, 5));
        step(2); check("R2 serial addr next", rb_data, pat(9, 6));
        line_start(2, 2'b10);
        step(2); check("R5 jump hold line", rb_data, pat(9, 5));
        line_start(2, 2'b01);
        step(2); check("R4 line hold col 0", rb_data, pat(9, 0));
        line_start(2, 2'b11);
        step(2); check("R6 jump next line", rb_data, pat(10, 5));

        // R2 clamp
        load(2, 1000, 400);
        line_start(2, 2'b00);
        step(2); check("R2 clamp", rb_data, pat(LINES - 1, COLS - 1));
        step(2); check("R7 clamp end hold", rb_data, pat(LINES - 1, COLS - 1));

        // R8 write mask
        load(0, 3, 4);
        line_start(0, 2'b00);
        wr_ie = 1'b0; wr_data = 8'hAA;
        step(0); step(0); step(0);
        wr_ie = 1'b1; wr_data = 8'h55;
        step(0);
        load(1, 3, 4);
        line_start(1, 2'b00);
        step(1); check("R8 masked c3", ra_data, pat(4, 3));
        step(1); check("R8 masked c4", ra_data, pat(4, 4));
        step(1); check("R8 masked c5", ra_data, pat(4, 5));
        step(1); check("R8 col advanced", ra_data, 8'h55);

        // R9 same-cycle write and read
        load(0, 0, 7);
        load(1, 0, 7);
        lst[0] = 1'b1; lst[1] = 1'b1; md[0] = 2'b00; md[1] = 2'b00;
        @(negedge clk);
        lst = '0;
        stp[0] = 1'b1; stp[1] = 1'b1; wr_data = 8'h3C;
        @(negedge clk);
        stp = '0;
        check("R9 same cycle old data", ra_data, pat(7, 0));
        line_start(1, 2'b01);
        step(1); check("R9 reread new data", ra_data, 8'h3C);

        // R10 line start and step together on port B
        load(2, 2, 4);
        line_start(2, 2'b00);
        step(2); check("R10 setup c2", rb_data, pat(4, 2));
        step(2); check("R10 setup c3", rb_data, pat(4, 3));
        check("R11 port A untouched", ra_data, 8'h3C);
        lst[2] = 1'b1; md[2] = 2'b10; stp[2] = 1'b1;
        @(negedge clk);
        lst[2] = 1'b0; stp[2] = 1'b0;
        check("R10 step discarded", rb_data, pat(4, 3));
        step(2); check("R10 start applied", rb_data, pat(4, 2));

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule